// File: doc/BRIEF.md
# Load/Store Line Clash Matrix

This block keeps a pairwise clash record between the memory line requests that are in flight in a load/store pipeline. Every load/store unit may split one access into two line requests, so the block has two slots per unit. A slot holds the part of the address that picks a line below the page boundary (address bits 11 down to 4) and a 16-bit byte mask for the bytes touched inside that 16-byte line.

When a request is allocated into a slot, it is compared against every other live slot in the same cycle. Two requests clash when their bits 11..4 match and their byte masks share at least one set bit. The comparison is deliberately conservative. Requests that differ only above bit 11 are still reported as clashing. That is a harmless false clash, but no real byte overlap is ever missed.

For every slot the block drives a clash-free flag. The issue logic uses it to send requests that cannot conflict with anything still in flight. Retiring a slot frees it and removes all of its clash bits, which may release the requests it was blocking.

Top module: `lsq_clash_matrix`

## Requirements
- R1: After reset every slot is empty and every bit of `clash_free_o` is 0.
- R2: The cycle after an allocate, the allocated slot is live. Its `clash_free_o` bit is 1 when it clashes with no other live slot.
- R3: A new request clashes with a live slot when address bits 11..4 are equal and the AND of the two masks is non-zero. The clash drives the `clash_free_o` bits of both slots to 0 from the next cycle on.
- R4: A request whose address bits 11..4 differ from those of a live slot does not clash with it, even when the masks overlap.
- R5: Address bits 3..0 and bits above 11 take no part in the comparison. Requests that differ only in those bits are compared as if equal, so a false clash above the page bits is reported.
- R6: Requests with disjoint masks do not clash. A request with an all-zero mask never clashes with anything.
- R7: When a slot retires, its `clash_free_o` bit is 0 from the next cycle on. All of its clash bits are cleared, so a partner that has no other clash becomes clash-free.
- R8: An allocate and a retire of different slots may happen in the same cycle. The new request is not compared against the slot that is retiring.
- R9: An allocate and a retire of the same slot in the same cycle leave the slot live and holding the new request.
- R10: In a cycle with neither allocate nor retire, `clash_free_o` does not change.
- R11: Allocating into a slot that is already live replaces the old request. The old request's clash bits are dropped, and the new request is compared against the other slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alloc_valid_i | input | 1 | Allocate a request this cycle |
| alloc_slot_i | input | IDX_W (3) | Slot that receives the request |
| alloc_addr_i | input | ADDR_W (32) | Request address; only bits 11..4 are used |
| alloc_mask_i | input | 16 | Byte mask inside the 16-byte line |
| retire_valid_i | input | 1 | Retire a slot this cycle |
| retire_slot_i | input | IDX_W (3) | Slot to retire |
| clash_free_o | output | NUM_SLOTS (8) | Per slot: live and clashing with no other live slot |

## Verification
The bench builds the block with its default parameters: four units with two requests each, so eight slots. That is enough for one request to clash with several partners at once, and for a retire to release one partner while another is still blocked. The directed sequences use addresses that differ in bits 3..0, in bits 11..4 and above bit 11, and they cover same-slot and cross-slot allocate/retire in one cycle. A long random phase draws bits 11..4 from only four values, so clashes are dense and chains of clashes build up and unwind.

// File: rtl/lsq_clash_pkg.sv
package lsq_clash_pkg;
    localparam int unsigned LINE_LSB   = 4;
    localparam int unsigned LINE_MSB   = 11;
    localparam int unsigned LINE_W     = LINE_MSB - LINE_LSB + 1;
    localparam int unsigned BYTE_LANES = 16;

    typedef logic [LINE_W-1:0]     line_tag_t;
    typedef logic [BYTE_LANES-1:0] byte_mask_t;

    // Flat index of the pair (lo, hi), lo < hi, in an upper-triangle store.
    function automatic int unsigned pair_index(int unsigned n, int unsigned lo, int unsigned hi);
        return lo * n - (lo * (lo + 1)) / 2 + (hi - lo - 1);
    endfunction
endpackage

// File: rtl/clash_cmp.sv
module clash_cmp
    import lsq_clash_pkg::*;
(
    input  line_tag_t  tag_a_i,
    input  byte_mask_t mask_a_i,
    input  line_tag_t  tag_b_i,
    input  byte_mask_t mask_b_i,
    output logic       hit_o
);
    logic same_line;
    logic lanes_shared;

    always_comb begin
        same_line    = (tag_a_i == tag_b_i);
        lanes_shared = |(mask_a_i & mask_b_i);
        hit_o        = same_line && lanes_shared;
    end
endmodule

// File: rtl/clash_free_cell.sv
module clash_free_cell #(
    parameter int unsigned NUM_SLOTS = 8
) (
    input  logic                 live_i,
    input  logic [NUM_SLOTS-1:0] row_i,
    output logic                 free_o
);
    always_comb begin
        free_o = live_i && (row_i == '0);
    end
endmodule

// File: rtl/lsq_clash_matrix.sv
module lsq_clash_matrix
    import lsq_clash_pkg::*;
#(
    parameter int unsigned NUM_UNITS    = 4,
    parameter int unsigned REQ_PER_UNIT = 2,
    parameter int unsigned ADDR_W       = 32,
    localparam int unsigned NUM_SLOTS   = NUM_UNITS * REQ_PER_UNIT,
    localparam int unsigned IDX_W       = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 alloc_valid_i,
    input  logic [IDX_W-1:0]     alloc_slot_i,
    input  logic [ADDR_W-1:0]    alloc_addr_i,
    input  logic [BYTE_LANES-1:0] alloc_mask_i,
    input  logic                 retire_valid_i,
    input  logic [IDX_W-1:0]     retire_slot_i,
    output logic [NUM_SLOTS-1:0] clash_free_o
);
    localparam int unsigned NUM_PAIRS = NUM_SLOTS * (NUM_SLOTS - 1) / 2;
    localparam int unsigned PAIR_W    = (NUM_PAIRS > 0) ? NUM_PAIRS : 1;

    typedef struct packed {
        logic [NUM_SLOTS-1:0]       live;
        line_tag_t [NUM_SLOTS-1:0]  tag;
        byte_mask_t [NUM_SLOTS-1:0] mask;
        logic [PAIR_W-1:0]          pair;
    } state_t;

    state_t state_d, state_q;

    line_tag_t            new_tag;
    logic [NUM_SLOTS-1:0] hit;
    logic [NUM_SLOTS-1:0] alloc_vec;
    logic [NUM_SLOTS-1:0] retire_vec;
    logic [NUM_SLOTS-1:0] cand;
    logic [NUM_SLOTS-1:0] row [NUM_SLOTS];

    assign new_tag = alloc_addr_i[LINE_MSB:LINE_LSB];

    // One comparator per slot: the new request against each stored one.
    for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_cmp
        clash_cmp u_cmp (
            .tag_a_i  (new_tag),
            .mask_a_i (alloc_mask_i),
            .tag_b_i  (state_q.tag[k]),
            .mask_b_i (state_q.mask[k]),
            .hit_o    (hit[k])
        );
    end

    always_comb begin
        for (int i = 0; i < NUM_SLOTS; i++) begin
            alloc_vec[i]  = alloc_valid_i  && (alloc_slot_i  == IDX_W'(i));
            retire_vec[i] = retire_valid_i && (retire_slot_i == IDX_W'(i));
            cand[i]       = hit[i] && state_q.live[i] && !retire_vec[i] && !alloc_vec[i];
        end
    end

    always_comb begin
        state_d = state_q;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (retire_vec[i]) begin
                state_d.live[i] = 1'b0;
            end
            if (alloc_vec[i]) begin
                state_d.live[i] = 1'b1;
                state_d.tag[i]  = new_tag;
                state_d.mask[i] = alloc_mask_i;
            end
        end
        for (int i = 0; i < NUM_SLOTS; i++) begin
            for (int j = i + 1; j < NUM_SLOTS; j++) begin
                int unsigned p;
                p = pair_index(NUM_SLOTS, i, j);
                if (retire_vec[i] || retire_vec[j] || alloc_vec[i] || alloc_vec[j]) begin
                    state_d.pair[p] = 1'b0;
                end
                if (alloc_vec[i]) begin
                    state_d.pair[p] = cand[j];
                end else if (alloc_vec[j]) begin
                    state_d.pair[p] = cand[i];
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    // Expand the triangle into full rows for the per-slot reduction.
    always_comb begin
        for (int i = 0; i < NUM_SLOTS; i++) begin
            for (int j = 0; j < NUM_SLOTS; j++) begin
                if (i < j) begin
                    row[i][j] = state_q.pair[pair_index(NUM_SLOTS, i, j)];
                end else if (j < i) begin
                    row[i][j] = state_q.pair[pair_index(NUM_SLOTS, j, i)];
                end else begin
                    row[i][j] = 1'b0;
                end
            end
        end
    end

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_free
        clash_free_cell #(.NUM_SLOTS(NUM_SLOTS)) u_free (
            .live_i (state_q.live[i]),
            .row_i  (row[i]),
            .free_o (clash_free_o[i])
        );
    end

    // ---------------- assertions ----------------
    logic orphan_pair;
    always_comb begin
        orphan_pair = 1'b0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            for (int j = i + 1; j < NUM_SLOTS; j++) begin
                if (state_q.pair[pair_index(NUM_SLOTS, i, j)] && !(state_q.live[i] && state_q.live[j])) begin
                    orphan_pair = 1'b1;
                end
            end
        end
    end

    assert_pair_needs_live_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !orphan_pair);

    assert_retire_blocks_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (retire_valid_i && !(alloc_valid_i && alloc_slot_i == retire_slot_i))
        |=> !clash_free_o[$past(retire_slot_i)]);

    assert_zero_mask_free_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (alloc_valid_i && alloc_mask_i == '0) |=> clash_free_o[$past(alloc_slot_i)]);

    assert_idle_stable_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!alloc_valid_i && !retire_valid_i) |=> $stable(clash_free_o));
endmodule

// File: tb/lsq_clash_matrix_tb_top.sv
module lsq_clash_matrix_tb_top;
    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        a_v = 1'b0;
    logic [2:0]  a_slot = '0;
    logic [31:0] a_addr = '0;
    logic [15:0] a_mask = '0;
    logic        r_v = 1'b0;
    logic [2:0]  r_slot = '0;
    logic [N-1:0] free;

    always #2 clk = ~clk; // 250 MHz

    lsq_clash_matrix dut_i (
        .clk_i(clk), .rst_ni(rst_n),
        .alloc_valid_i(a_v), .alloc_slot_i(a_slot), .alloc_addr_i(a_addr), .alloc_mask_i(a_mask),
        .retire_valid_i(r_v), .retire_slot_i(r_slot),
        .clash_free_o(free)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference model
    bit        m_live [N];
    bit [7:0]  m_tag  [N];
    bit [15:0] m_mask [N];
    bit        m_cl   [N][N];

    typedef struct { logic [N-1:0] exp; string req; } item_t;
    item_t sb_q[$];

    function automatic logic [N-1:0] model_free();
        logic [N-1:0] f;
        for (int i = 0; i < N; i++) begin
            f[i] = m_live[i];
            for (int j = 0; j < N; j++) if (m_cl[i][j]) f[i] = 1'b0;
        end
        return f;
    endfunction

    task automatic step(input bit av, input int as, input logic [31:0] ad, input logic [15:0] am,
                        input bit rv, input int rs, input string req);
        item_t it;
        @(negedge clk);
        a_v = av; a_slot = 3'(as); a_addr = ad; a_mask = am;
        r_v = rv; r_slot = 3'(rs);
        if (rv) begin
            m_live[rs] = 1'b0;
            for (int k = 0; k < N; k++) begin m_cl[rs][k] = 1'b0; m_cl[k][rs] = 1'b0; end
        end
        if (av) begin
            for (int k = 0; k < N; k++) begin m_cl[as][k] = 1'b0; m_cl[k][as] = 1'b0; end
            for (int k = 0; k < N; k++) begin
                if (k != as && m_live[k] && m_tag[k] == ad[11:4] && (m_mask[k] & am) != 0) begin
                    m_cl[as][k] = 1'b1; m_cl[k][as] = 1'b1;
                end
            end
            m_live[as] = 1'b1; m_tag[as] = ad[11:4]; m_mask[as] = am;
        end
        @(posedge clk);
        #1;
        it.exp = model_free();
        it.req = req;
        sb_q.push_back(it);
        a_v = 1'b0; r_v = 1'b0;
    endtask

    // Monitor: compares one expected item per cycle, away from the edge.
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            checks++;
            if (free !== it.exp) begin
                errors++;
                $display("FAIL %s: clash_free_o=%b expected %b", it.req, free, it.exp);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            m_live[i] = 0; m_tag[i] = 0; m_mask[i] = 0;
            for (int j = 0; j < N; j++) m_cl[i][j] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (free !== '0) begin
            errors++;
            $display("FAIL R1: clash_free_o=%b expected %b", free, {N{1'b0}});
        end
        rst_n = 1'b1;

        // R2: lone request is clash-free
        step(1, 0, 32'h0000_0120, 16'h000F, 0, 0, "R2");
        // R3: same bits 11..4, overlapping mask -> both blocked
        step(1, 1, 32'h0000_0128, 16'h0018, 0, 0, "R3");
        // R6: disjoint mask on same line -> free
        step(1, 2, 32'h0000_0120, 16'hF000, 0, 0, "R6");
        // R4: different bits 11..4, overlapping mask -> free
        step(1, 3, 32'h0000_0130, 16'h000F, 0, 0, "R4");
        // R5: differs above bit 11 and in bits 3..0 -> still clashes with slot 3
        step(1, 4, 32'h0005_F137, 16'h0001, 0, 0, "R5");
        // R6: zero mask never clashes
        step(1, 5, 32'h0000_0120, 16'h0000, 0, 0, "R6");
        // R10: idle cycle keeps outputs
        step(0, 0, 32'h0, 16'h0, 0, 0, "R10");
        // R7: retire slot 0 releases slot 1
        step(0, 0, 32'h0, 16'h0, 1, 0, "R7");
        // R8: alloc slot 6 matching retiring slot 3 while 3 retires
        step(1, 6, 32'h0000_0130, 16'h0001, 1, 3, "R8");
        // R9: same-slot alloc and retire -> new request stays
        step(1, 6, 32'h0000_0200, 16'h0001, 1, 6, "R9");
        // R11: overwrite slot 2 to clash with slot 1, then overwrite away
        step(1, 2, 32'h0000_0120, 16'h0010, 0, 0, "R11");
        step(1, 2, 32'h0000_0FF0, 16'h0010, 0, 0, "R11");
        // R3: one request clashing with two partners, then R7 partial release
        step(1, 7, 32'h0000_0120, 16'h0030, 0, 0, "R3");
        step(1, 0, 32'h0000_0120, 16'h0020, 0, 0, "R3");
        step(0, 0, 32'h0, 16'h0, 1, 1, "R7");
        step(0, 0, 32'h0, 16'h0, 1, 0, "R7");

        // Dense random phase
        for (int n = 0; n < 400; n++) begin
            bit av, rv;
            int as, rs;
            logic [31:0] ad;
            av = ($urandom_range(0, 3) != 0);
            rv = ($urandom_range(0, 2) == 0);
            as = $urandom_range(0, N - 1);
            rs = $urandom_range(0, N - 1);
            ad = $urandom;
            ad[11:4] = 8'(8'h40 + $urandom_range(0, 3));
            step(av, as, ad, 16'($urandom_range(0, 65535)) & 16'($urandom_range(0, 65535)),
                 rv, rs, "R3");
        end

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule